// File: doc/BRIEF.md
# T1 Ones-Density Guard

This block watches two serial T1 bit streams, an outgoing one and an incoming one. Each stream advances by one bit on every clock where its valid strobe is high. The block reports every bit at which a stream breaks the T1 ones-density rule. There are two parts to that rule. A stream may not run more than fifteen zeros in a row. For each N from 1 to 23, every span of 8·(N+1) consecutive bits must hold at least N ones, so the longest span checked is 192 bits. Checking runs on both streams at all times, whatever the enforcement setting.

When enforcement is switched on, the outgoing stream is also corrected before it leaves the block. A zero is turned into a one only when sending that zero would break the rule. Every other bit goes out untouched, so the corrected stream stays compliant whatever data arrives. Enforcement should be left off when the line already uses a zero-substitution code, because such a code cannot break the rule.

Top module: `t1_density_guard`

## Requirements
- R1: A stream is in violation on the bit that is the sixteenth (or later) zero in a row. The first fifteen zeros after reset raise no flag, and the sixteenth one does.
- R2: For each N in 1..23, a stream is in violation on any bit that closes a span of 8·(N+1) bits holding fewer than N ones.
- R3: Each accepted bit whose acceptance breaks R1 or R2 raises a one-clock pulse one clock later. `tx_viol` covers the uncorrected outgoing input and `rx_viol` covers the incoming stream. Both checks are independent of `enf_en`.
- R4: While `enf_en` is high, the corrected stream (`txo_bit` on each `txo_vld`) never breaks R1 or R2.
- R5: While `enf_en` is high, a zero is replaced by a one exactly when sending the zero would break R1 or R2. Ones, and zeros that break nothing, pass through unchanged, so a compliant stream leaves the block bit for bit.
- R6: While `enf_en` is low, `txo_bit` equals the accepted `tx_bit`.
- R7: `txo_vld` is high exactly one clock after each cycle in which `tx_vld` is high, and `txo_bit` carries that bit's corrected value.
- R8: After a synchronous reset, all pulses, sticky flags and `txo_vld` are low. Every history counts as 192 ones.
- R9: `tx_viol_sticky`/`rx_viol_sticky` rise together with their pulse and stay high until a cycle with `sticky_clr` high that carries no new pulse. If a clear and a pulse arrive in the same cycle, the flag stays set.
- R10: Cycles with a stream's valid strobe low leave that stream's history untouched and raise no pulse or output strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_vld | input | 1 | Outgoing bit present this cycle |
| tx_bit | input | 1 | Outgoing bit before correction |
| rx_vld | input | 1 | Incoming bit present this cycle |
| rx_bit | input | 1 | Incoming bit |
| enf_en | input | 1 | Enable correction of the outgoing stream |
| sticky_clr | input | 1 | Clear both sticky flags |
| txo_vld | output | 1 | Corrected bit present (one clock after `tx_vld`) |
| txo_bit | output | 1 | Corrected outgoing bit |
| tx_viol | output | 1 | Pulse: outgoing input broke the rule |
| rx_viol | output | 1 | Pulse: incoming stream broke the rule |
| tx_viol_sticky | output | 1 | Held outgoing violation flag |
| rx_viol_sticky | output | 1 | Held incoming violation flag |

## Verification
The bench aims at the sixteenth zero after reset. If the history were not preset to ones, the first pulse would come at the wrong bit, and an off-by-one zero-run limit would let a sixteen-zero gap leave the block. An incoming pattern with one one per sixteen bits meets the run limit but fails only the longer spans, which exposes a window counter with a wrong length or a missing leaving bit. Compliant and sparse random outgoing data check that the enforcer never inserts an unneeded one and never lets a gap through. Idle cycles, a clear that coincides with a pulse, and a final stretch with enforcement off expose a history that shifts without a valid strobe, a clear that wins over a set, and a pass-through that still alters bits.

// File: rtl/t1pd_pkg.sv
package t1pd_pkg;

    localparam int GRP      = 8;                    // span grows by this many bits per step of N
    localparam int N_MAX    = 23;                   // largest ones requirement
    localparam int HIST     = GRP * (N_MAX + 1);    // longest span
    localparam int ZRUN_LIM = 15;                   // zeros allowed in a row
    localparam int CW       = $clog2(HIST + 1);
    localparam int ZW       = $clog2(ZRUN_LIM + 2);

    typedef struct packed {
        logic vld;
        logic data;
    } lbit_t;

    function automatic int span_len(input int k);
        return GRP * (k + 2);
    endfunction

endpackage

// File: rtl/t1pd_tracker.sv
module t1pd_tracker
    import t1pd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic commit_vld,
    input  logic commit_bit,
    input  logic cand_bit,
    output logic brk
);

    logic [HIST-1:0]  hist;     // bit 0 holds the newest bit
    logic [ZW-1:0]    zrun;
    logic [N_MAX-1:0] short0;
    logic [N_MAX-1:0] short1;

    generate
        for (genvar k = 0; k < N_MAX; k++) begin : g_span
            localparam int            L    = span_len(k);
            localparam logic [CW-1:0] NEED = CW'(k + 1);
            logic [CW-1:0] cnt;
            logic          leave;

            assign leave     = hist[L-1];
            assign short0[k] = cnt < (NEED + CW'(leave));
            assign short1[k] = (cnt + CW'(1)) < (NEED + CW'(leave));

            always_ff @(posedge clk) begin
                if (rst)
                    cnt <= CW'(L);
                else if (commit_vld)
                    cnt <= cnt + CW'(commit_bit) - CW'(leave);
            end

            assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
                cnt <= CW'(L));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '1;
            zrun <= '0;
        end else if (commit_vld) begin
            hist <= {hist[HIST-2:0], commit_bit};
            if (commit_bit)
                zrun <= '0;
            else if (zrun != ZW'(ZRUN_LIM + 1))
                zrun <= zrun + ZW'(1);
        end
    end

    always_comb begin
        if (cand_bit)
            brk = |short1;
        else
            brk = (|short0) || (zrun >= ZW'(ZRUN_LIM));
    end

    assert_zrun_sat_R1: assert property (@(posedge clk) disable iff (rst)
        zrun <= ZW'(ZRUN_LIM + 1));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !commit_vld |=> $stable(hist));

endmodule

// File: rtl/t1pd_monitor.sv
module t1pd_monitor
    import t1pd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic din,
    input  logic clr,
    output logic viol,
    output logic sticky
);

    logic brk;
    logic hit;

    t1pd_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .commit_vld (vld),
        .commit_bit (din),
        .cand_bit   (din),
        .brk        (brk)
    );

    assign hit = vld & brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            viol   <= 1'b0;
            sticky <= 1'b0;
        end else begin
            viol   <= hit;
            sticky <= (sticky & ~clr) | hit;
        end
    end

    assert_pulse_sets_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        viol |-> sticky);

    assert_sticky_only_clears_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(sticky) |-> $past(clr));

    assert_no_pulse_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !vld |=> !viol);

endmodule

// File: rtl/t1pd_enforcer.sv
module t1pd_enforcer
    import t1pd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  vld,
    input  logic  din,
    input  logic  en,
    output lbit_t out
);

    logic zero_brk;
    logic sent;

    t1pd_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .commit_vld (vld),
        .commit_bit (sent),
        .cand_bit   (1'b0),
        .brk        (zero_brk)
    );

    assign sent = din | (en & zero_brk);

    always_ff @(posedge clk) begin
        if (rst) begin
            out <= '0;
        end else begin
            out.vld  <= vld;
            out.data <= vld & sent;
        end
    end

    assert_forced_one_R5: assert property (@(posedge clk) disable iff (rst)
        vld && en && zero_brk |=> out.data);

    assert_keep_free_zero_R5: assert property (@(posedge clk) disable iff (rst)
        vld && en && !din && !zero_brk |=> !out.data);

    assert_passthrough_R6: assert property (@(posedge clk) disable iff (rst)
        vld && !en |=> out.data == $past(din));

    assert_out_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        out.vld == $past(vld));

endmodule

// File: rtl/t1_density_guard.sv
module t1_density_guard
    import t1pd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tx_vld,
    input  logic tx_bit,
    input  logic rx_vld,
    input  logic rx_bit,
    input  logic enf_en,
    input  logic sticky_clr,
    output logic txo_vld,
    output logic txo_bit,
    output logic tx_viol,
    output logic rx_viol,
    output logic tx_viol_sticky,
    output logic rx_viol_sticky
);

    lbit_t txo;

    t1pd_monitor u_mon_tx (
        .clk    (clk),
        .rst    (rst),
        .vld    (tx_vld),
        .din    (tx_bit),
        .clr    (sticky_clr),
        .viol   (tx_viol),
        .sticky (tx_viol_sticky)
    );

    t1pd_monitor u_mon_rx (
        .clk    (clk),
        .rst    (rst),
        .vld    (rx_vld),
        .din    (rx_bit),
        .clr    (sticky_clr),
        .viol   (rx_viol),
        .sticky (rx_viol_sticky)
    );

    t1pd_enforcer u_enf (
        .clk (clk),
        .rst (rst),
        .vld (tx_vld),
        .din (tx_bit),
        .en  (enf_en),
        .out (txo)
    );

    assign txo_vld = txo.vld;
    assign txo_bit = txo.data;

    assert_reset_quiet_R8: assert property (@(posedge clk)
        $past(rst) |-> !txo_vld && !tx_viol && !rx_viol && !tx_viol_sticky && !rx_viol_sticky);

endmodule

// File: tb/t1_density_guard_test.sv
module t1_density_guard_test;

    localparam int PERIOD = 10;
    localparam int HB     = 192;

    logic clk = 1'b0;
    logic rst, tx_vld, tx_bit, rx_vld, rx_bit, enf_en, sticky_clr;
    logic txo_vld, txo_bit, tx_viol, rx_viol, tx_viol_sticky, rx_viol_sticky;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    logic [HB-1:0] h_tx, h_rx, h_out;   // bit 0 newest, bench model
    int first_tx_viol;
    int bitno;

    always #(PERIOD/2) clk = ~clk;

    t1_density_guard uut (
        .clk(clk), .rst(rst), .tx_vld(tx_vld), .tx_bit(tx_bit),
        .rx_vld(rx_vld), .rx_bit(rx_bit), .enf_en(enf_en), .sticky_clr(sticky_clr),
        .txo_vld(txo_vld), .txo_bit(txo_bit), .tx_viol(tx_viol), .rx_viol(rx_viol),
        .tx_viol_sticky(tx_viol_sticky), .rx_viol_sticky(rx_viol_sticky)
    );

    // true if the history (newest in bit 0) breaks the run limit or a span rule
    function automatic bit broken(input logic [HB-1:0] h);
        int zr = 0;
        while (zr < HB && h[zr] == 1'b0) zr++;
        if (zr > 15) return 1'b1;
        for (int n = 1; n <= 23; n++) begin
            int ones = 0;
            for (int i = 0; i < 8 * (n + 1); i++) ones += int'(h[i]);
            if (ones < n) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d (bit %0d)", req, act, exp, bitno);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; tx_vld = 0; rx_vld = 0; tx_bit = 0; rx_bit = 0; sticky_clr = 0;
        @(negedge clk); @(negedge clk);
        rst = 0;
        h_tx = '1; h_rx = '1; h_out = '1;
        bitno = 0; first_tx_viol = -1;
    endtask

    // apply one cycle at a falling edge, check results at the next falling edge
    task automatic step(input bit tv, input bit tb, input bit rv, input bit rb, input bit clr);
        bit exp_tv, exp_rv, exp_o;
        logic [HB-1:0] nt, nr, no;
        tx_vld = tv; tx_bit = tb; rx_vld = rv; rx_bit = rb; sticky_clr = clr;
        exp_tv = 0; exp_rv = 0; exp_o = tb;
        if (tv) begin
            nt = {h_tx[HB-2:0], tb};
            exp_tv = broken(nt);
            h_tx = nt;
            if (enf_en && broken({h_out[HB-2:0], 1'b0})) exp_o = 1'b1;
            no = {h_out[HB-2:0], exp_o};
            if (enf_en) check(!broken(no), "R4", int'(broken(no)), 0);
            h_out = no;
        end
        if (rv) begin
            nr = {h_rx[HB-2:0], rb};
            exp_rv = broken(nr);
            h_rx = nr;
        end
        @(negedge clk);
        bitno++;
        tx_vld = 0; rx_vld = 0; sticky_clr = 0;
        check(txo_vld == tv, "R7", int'(txo_vld), int'(tv));
        if (tv) check(txo_bit == exp_o, enf_en ? "R5" : "R6", int'(txo_bit), int'(exp_o));
        check(tx_viol == exp_tv, tv ? "R1/R2/R3" : "R10", int'(tx_viol), int'(exp_tv));
        check(rx_viol == exp_rv, rv ? "R1/R2/R3" : "R10", int'(rx_viol), int'(exp_rv));
        if (tx_viol && first_tx_viol < 0) first_tx_viol = bitno;
    endtask

    initial begin
        #(PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int mism;
        void'($urandom(32'h5eed_0017));
        enf_en = 1;
        do_reset();

        // R8: reset state
        check(!txo_vld && !tx_viol && !rx_viol, "R8", int'(txo_vld | tx_viol | rx_viol), 0);
        check(!tx_viol_sticky && !rx_viol_sticky, "R8", int'(tx_viol_sticky | rx_viol_sticky), 0);

        // R1: all-zero outgoing input, incoming all ones
        for (int i = 0; i < 400; i++) step(1, 0, 1, 1, 0);
        check(first_tx_viol == 16, "R1", first_tx_viol, 16);
        check(tx_viol_sticky == 1, "R9", int'(tx_viol_sticky), 1);
        check(rx_viol_sticky == 0, "R3", int'(rx_viol_sticky), 0);

        // R9: clear coinciding with a fresh pulse keeps the flag set
        step(1, 0, 0, 0, 1);
        check(tx_viol_sticky == 1, "R9", int'(tx_viol_sticky), 1);
        // R9: clear on an idle cycle drops it
        step(0, 0, 0, 0, 1);
        check(tx_viol_sticky == 0, "R9", int'(tx_viol_sticky), 0);

        // R10: idle cycles
        for (int i = 0; i < 20; i++) step(0, 1, 0, 0, 0);

        // R5: compliant stream passes bit for bit; incoming stream breaks only long spans (R2)
        do_reset();
        mism = 0;
        for (int i = 0; i < 800; i++) begin
            step(1, (i % 8) == 3, 1, (i % 16) == 0, 0);
            if (txo_bit != ((i % 8) == 3)) mism++;
        end
        check(mism == 0, "R5", mism, 0);
        check(rx_viol_sticky == 1, "R2", int'(rx_viol_sticky), 1);
        check(tx_viol_sticky == 0, "R2", int'(tx_viol_sticky), 0);

        // R4/R5: sparse random outgoing data with random gaps
        do_reset();
        for (int i = 0; i < 1500; i++)
            step(($urandom % 5) != 0, ($urandom % 10) == 0, ($urandom % 4) != 0,
                 ($urandom % 12) == 0, ($urandom % 50) == 0);

        // R6: enforcement off, sparse random data passes unchanged
        enf_en = 0;
        do_reset();
        for (int i = 0; i < 800; i++)
            step(($urandom % 6) != 0, ($urandom % 9) == 0, 1, ($urandom % 3) == 0, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule